// File: doc/BRIEF.md
# Region Statistics Accumulator

This block collects statistics over one frame of streamed pixels. The frame is marked by a start flag on its first beat and an end flag on its last beat. Beats move on a valid/ready handshake. Three 16-bit inputs arrive with every beat.

The mode, the tie rule and the line length are sampled on the start beat, and one shared engine serves three modes:

- **Motion mode** treats the inputs as signed temporal, horizontal and vertical gradients. It produces six sums of gradient products.
- **Mean/variance mode** treats input 0 as an unsigned image sample and input 1 as a mask. It produces the sum of squares, the sum, and the number of valid pixels.
- **Extreme mode** uses the same image and mask inputs. It produces the minimum and maximum sample values and where each one was found.

The engine tracks positions internally. A column counter starts at zero on the start beat and wraps at the line length, and a row counter advances on each wrap. When the frame ends, the finished statistics are copied into a bank of six result slots, and a one-cycle done pulse announces them. Software or a downstream block then reads the slots by index. Division and square roots are left to whoever consumes the slots.

Top module: `roi_stat_engine`

## Requirements
- R1: After reset every result slot reads zero, `done` is low and `in_ready` is high.
- R2: Motion mode (mode code 0) uses signed inputs. The slots hold the low 32 bits of these sums, in this order:
  - slot 0: Σp0·p1
  - slot 1: Σp0·p2
  - slot 2: Σp1·p2
  - slot 3: Σp1²
  - slot 4: Σp2²
  - slot 5: Σ|p0|
- R3: Mean/variance mode (mode code 1) uses unsigned p0 and fills the slots as follows:
  - slot 0: bits 31:0 of Σp0²
  - slot 1: bits 63:32 of Σp0²
  - slot 2: bits 31:0 of Σp0
  - slot 3: bits 63:32 of Σp0
  - slot 4: the valid-pixel count
  - slot 5: zero
- R4: In modes 1 and 2 a pixel is valid only when the mask input p1 is nonzero. Pixels that are not valid add nothing to any result.
- R5: Extreme mode (mode code 2) fills the slots as follows:
  - slot 0: the valid count
  - slot 1: the position of the minimum
  - slot 2: the position of the maximum
  - slot 3: the minimum value (unsigned p0)
  - slot 4: the maximum value
  - slot 5: zero

  A position packs the column in bits 15:0 and the row in bits 31:16. The column is 0 on the start beat, counts accepted beats, and returns to 0 after reaching line length minus 1, at which point the row increments.
- R6: When a new value equals the current extreme, the tie bit decides which position is reported. With tie bit 1 the earliest position is kept; with tie bit 0 the latest position replaces it.
- R7: A mode-2 frame with no valid pixel reports zero in slots 0 to 4.
- R8: The slots and `done` change on the second rising edge after the end beat is accepted. `done` is high for exactly one cycle. `in_ready` is low for the single cycle between those edges and high otherwise.
- R9: Every statistic restarts on the start beat, so no result carries anything from an earlier frame.
- R10: Mode, tie bit and line length are taken from the configuration inputs on the start beat only. Changing them later in the frame has no effect on that frame.
- R11: Indices 6 and 7 read zero, and mode code 3 produces all-zero slots.
- R12: Cycles without `in_valid` change nothing, whatever values the data, start and end inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Statistics mode: 0 motion, 1 mean/variance, 2 extreme, 3 none |
| cfg_tie_first | input | 1 | Tie rule: 1 keeps the first position, 0 the last |
| cfg_line_len | input | 16 | Pixels per row, used for position counting |
| in_valid | input | 1 | Beat carries a pixel |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_sof | input | 1 | Beat is the first of a frame |
| in_eof | input | 1 | Beat is the last of a frame |
| in_p0 | input | 16 | Temporal gradient or image sample |
| in_p1 | input | 16 | Horizontal gradient or mask |
| in_p2 | input | 16 | Vertical gradient |
| rd_idx | input | 3 | Result slot index |
| rd_data | output | 32 | Content of the indexed slot |
| done | output | 1 | One-cycle pulse when new results are in the slots |

## Verification
The hardest cases to reach from the ports are ties on the extreme values and a frame whose configuration changes after the start beat. Both depend on history inside the frame, not on a single beat. The stimulus handles them with one fixed pixel list:

- Ties: the list holds repeated minimum and maximum samples with masks set, so runs with each tie setting must report different positions.
- Ignored cycles: idle cycles are inserted between beats, and they carry a set mask, an extreme sample and raised frame flags. Any leak through the handshake would therefore show in the results.
- Late configuration change: one run flips mode, tie bit and line length immediately after the start beat.
- Empty and one-pixel frames: an all-masked frame and a single-beat frame follow full frames, which exposes any stale state.

// File: rtl/roi_stat_pkg.sv
package roi_stat_pkg;

  localparam int PIX_W     = 16;
  localparam int ACC_W     = 64;
  localparam int SLOT_W    = 32;
  localparam int NUM_SLOTS = 6;
  localparam int IDX_W     = 3;
  localparam int CRD_W     = 16;
  localparam int POS_W     = 2 * CRD_W;
  localparam int PROD_W    = 2 * PIX_W;

  typedef enum logic [1:0] {
    MODE_MOTION  = 2'd0,
    MODE_MEANVAR = 2'd1,
    MODE_EXTREME = 2'd2,
    MODE_NONE    = 2'd3
  } stat_mode_e;

  // Contribution of one beat to accumulator lane 'lane'.
  function automatic logic [ACC_W-1:0] lane_term(
    input stat_mode_e       mode,
    input int               lane,
    input logic [PIX_W-1:0] a,
    input logic [PIX_W-1:0] b,
    input logic [PIX_W-1:0] c,
    input logic             pix_ok
  );
    logic signed [PROD_W-1:0] sa, sb, sc, prod;
    logic        [PROD_W-1:0] uprod;
    sa = PROD_W'($signed(a));
    sb = PROD_W'($signed(b));
    sc = PROD_W'($signed(c));
    prod  = '0;
    uprod = '0;
    lane_term = '0;
    if (mode == MODE_MOTION) begin
      case (lane)
        0:       prod = sa * sb;
        1:       prod = sa * sc;
        2:       prod = sb * sc;
        3:       prod = sb * sb;
        4:       prod = sc * sc;
        default: prod = (sa < 0) ? -sa : sa;
      endcase
      lane_term = ACC_W'(prod);
    end else if (mode == MODE_MEANVAR && pix_ok) begin
      if (lane == 0) begin
        uprod = PROD_W'(a) * PROD_W'(a);
        lane_term = ACC_W'(uprod);
      end else if (lane == 1) begin
        lane_term = ACC_W'(a);
      end
    end
  endfunction

  // True when value v should replace the current extreme 'best'.
  function automatic logic takes_over(
    input logic             find_max,
    input logic             tie_first,
    input logic [PIX_W-1:0] v,
    input logic [PIX_W-1:0] best
  );
    if (find_max) takes_over = tie_first ? (v > best) : (v >= best);
    else          takes_over = tie_first ? (v < best) : (v <= best);
  endfunction

endpackage

// File: rtl/roi_acc_lane.sv
module roi_acc_lane
  import roi_stat_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  stat_mode_e       mode,
  input  logic [PIX_W-1:0] a,
  input  logic [PIX_W-1:0] b,
  input  logic [PIX_W-1:0] c,
  input  logic             pix_ok,
  output logic [ACC_W-1:0] acc
);

  logic [ACC_W-1:0] term;
  assign term = lane_term(mode, LANE, a, b, c, pix_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (beat) acc <= sof ? term : acc + term;
  end

  // R12: idle cycles leave the sum untouched
  a_r12_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(acc));

  // R9: a start beat discards the previous frame
  a_r9_lane_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sof) |=> acc == $past(term));

endmodule

// File: rtl/roi_pos_track.sv
module roi_pos_track
  import roi_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic [CRD_W-1:0] line_len,
  output logic [CRD_W-1:0] cur_x,
  output logic [CRD_W-1:0] cur_y
);

  logic [CRD_W-1:0] nx_q, ny_q;
  logic             row_end;

  assign cur_x   = sof ? '0 : nx_q;
  assign cur_y   = sof ? '0 : ny_q;
  assign row_end = (cur_x == line_len - CRD_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nx_q <= '0;
      ny_q <= '0;
    end else if (beat) begin
      if (row_end) begin
        nx_q <= '0;
        ny_q <= cur_y + CRD_W'(1);
      end else begin
        nx_q <= cur_x + CRD_W'(1);
        ny_q <= cur_y;
      end
    end
  end

  // R5: column wraps at the line length and the row advances
  a_r5_row_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && row_end) |=> (nx_q == '0 && ny_q == $past(cur_y) + CRD_W'(1)));

  a_r5_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !row_end) |=> (nx_q == $past(cur_x) + CRD_W'(1) && ny_q == $past(cur_y)));

endmodule

// File: rtl/roi_extreme.sv
module roi_extreme
  import roi_stat_pkg::*;
#(
  parameter bit FIND_MAX = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic             pix_ok,
  input  logic             tie_first,
  input  logic [PIX_W-1:0] value,
  input  logic [POS_W-1:0] pos,
  output logic             found,
  output logic [PIX_W-1:0] best_val,
  output logic [POS_W-1:0] best_pos
);

  logic found_eff, take;

  assign found_eff = sof ? 1'b0 : found;
  assign take      = beat && pix_ok &&
                     (!found_eff || takes_over(FIND_MAX, tie_first, value, best_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found    <= 1'b0;
      best_val <= '0;
      best_pos <= '0;
    end else if (take) begin
      found    <= 1'b1;
      best_val <= value;
      best_pos <= pos;
    end else if (beat && sof) begin
      found    <= 1'b0;
      best_val <= '0;
      best_pos <= '0;
    end
  end

  // R6: equal value with first-occurrence rule keeps the old position
  a_r6_tie_keeps_first: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !sof && pix_ok && found && tie_first && value == best_val)
      |=> $stable(best_pos));

  // R6: equal value with last-occurrence rule moves to the new position
  a_r6_tie_takes_last: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !sof && pix_ok && found && !tie_first && value == best_val)
      |=> best_pos == $past(pos));

  // R4/R7: masked start beat leaves nothing found
  a_r7_masked_start: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sof && !pix_ok) |=> !found);

endmodule

// File: rtl/roi_stat_engine.sv
module roi_stat_engine
  import roi_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_tie_first,
  input  logic [CRD_W-1:0]  cfg_line_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [PIX_W-1:0]  in_p0,
  input  logic [PIX_W-1:0]  in_p1,
  input  logic [PIX_W-1:0]  in_p2,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [SLOT_W-1:0] rd_data,
  output logic              done
);

  localparam int NUM_EXT = 2;

  // named events
  logic beat, sof_beat, eof_beat, pix_ok, cap_pend;

  stat_mode_e       mode_q, mode_eff;
  logic             tie_q, tie_eff;
  logic [CRD_W-1:0] len_q, len_eff;

  logic [ACC_W-1:0]  acc [NUM_SLOTS];
  logic [SLOT_W-1:0] cnt_q;
  logic [CRD_W-1:0]  cur_x, cur_y;
  logic [POS_W-1:0]  cur_pos;

  logic [NUM_EXT-1:0] ext_found;
  logic [PIX_W-1:0]   ext_val [NUM_EXT];
  logic [POS_W-1:0]   ext_pos [NUM_EXT];

  logic [SLOT_W-1:0] slot_next [NUM_SLOTS];
  logic [SLOT_W-1:0] bank      [NUM_SLOTS];

  assign in_ready = !cap_pend;
  assign beat     = in_valid && in_ready;
  assign sof_beat = beat && in_sof;
  assign eof_beat = beat && in_eof;
  assign pix_ok   = |in_p1;

  // configuration sampled on the start beat
  assign mode_eff = in_sof ? stat_mode_e'(cfg_mode) : mode_q;
  assign tie_eff  = in_sof ? cfg_tie_first : tie_q;
  assign len_eff  = in_sof ? cfg_line_len  : len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_MOTION;
      tie_q  <= 1'b0;
      len_q  <= '0;
    end else if (sof_beat) begin
      mode_q <= stat_mode_e'(cfg_mode);
      tie_q  <= cfg_tie_first;
      len_q  <= cfg_line_len;
    end
  end

  // accumulator lanes
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_lane
    roi_acc_lane #(.LANE(g)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .beat   (beat),
      .sof    (in_sof),
      .mode   (mode_eff),
      .a      (in_p0),
      .b      (in_p1),
      .c      (in_p2),
      .pix_ok (pix_ok),
      .acc    (acc[g])
    );
  end

  // valid pixel count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (beat) cnt_q <= (in_sof ? '0 : cnt_q) + SLOT_W'(pix_ok);
  end

  roi_pos_track u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (beat),
    .sof      (in_sof),
    .line_len (len_eff),
    .cur_x    (cur_x),
    .cur_y    (cur_y)
  );
  assign cur_pos = {cur_y, cur_x};

  // index 0 tracks the minimum, index 1 the maximum
  for (genvar m = 0; m < NUM_EXT; m++) begin : g_ext
    roi_extreme #(.FIND_MAX(m == 1)) u_ext (
      .clk       (clk),
      .rst_n     (rst_n),
      .beat      (beat),
      .sof       (in_sof),
      .pix_ok    (pix_ok),
      .tie_first (tie_eff),
      .value     (in_p0),
      .pos       (cur_pos),
      .found     (ext_found[m]),
      .best_val  (ext_val[m]),
      .best_pos  (ext_pos[m])
    );
  end

  // slot packing per mode
  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) slot_next[s] = '0;
    case (mode_q)
      MODE_MOTION: begin
        for (int s = 0; s < NUM_SLOTS; s++) slot_next[s] = acc[s][SLOT_W-1:0];
      end
      MODE_MEANVAR: begin
        slot_next[0] = acc[0][SLOT_W-1:0];
        slot_next[1] = acc[0][ACC_W-1:SLOT_W];
        slot_next[2] = acc[1][SLOT_W-1:0];
        slot_next[3] = acc[1][ACC_W-1:SLOT_W];
        slot_next[4] = cnt_q;
      end
      MODE_EXTREME: begin
        slot_next[0] = cnt_q;
        slot_next[1] = ext_found[0] ? ext_pos[0] : '0;
        slot_next[2] = ext_found[1] ? ext_pos[1] : '0;
        slot_next[3] = ext_found[0] ? SLOT_W'(ext_val[0]) : '0;
        slot_next[4] = ext_found[1] ? SLOT_W'(ext_val[1]) : '0;
      end
      default: ;
    endcase
  end

  logic unused_hi;
  assign unused_hi = ^{acc[2][ACC_W-1:SLOT_W], acc[3][ACC_W-1:SLOT_W],
                       acc[4][ACC_W-1:SLOT_W], acc[5][ACC_W-1:SLOT_W]};

  // capture and done
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_pend <= 1'b0;
      done     <= 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++) bank[s] <= '0;
    end else begin
      cap_pend <= eof_beat;
      done     <= cap_pend;
      if (cap_pend) begin
        for (int s = 0; s < NUM_SLOTS; s++) bank[s] <= slot_next[s];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (rd_idx == IDX_W'(s)) rd_data = bank[s];
  end

  // R8: done lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: ready drops for exactly the cycle after the end beat
  a_r8_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
    eof_beat |=> !in_ready);

  a_r8_done_follows_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (done && in_ready));

  // R11: indices past the bank read zero
  a_r11_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_idx) >= NUM_SLOTS) |-> rd_data == '0);

  // R12: bank only moves when done rises
  a_r12_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(bank[0]));

  // R9: count restarts on the start beat
  a_r9_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sof_beat |=> cnt_q == SLOT_W'($past(pix_ok)));

endmodule

// File: tb/test_roi_stat_engine.sv
module test_roi_stat_engine;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  // beat list: {p0, p1, p2}
  localparam logic [47:0] VEC [NVEC] = '{
    48'h0005_0001_FFFE, 48'hFFFF_0000_0003, 48'h8000_0002_0007,
    48'h0005_0001_FFF0, 48'h0003_0001_0001, 48'hFFFF_0001_8000,
    48'h0003_0004_0010, 48'h1234_0000_0002, 48'hFFFF_0009_0000,
    48'h7FFF_0001_FFFF, 48'h0003_0002_0005, 48'h0100_0001_0001
  };

  typedef struct packed {
    logic [1:0]  mode;
    logic        tie;
    logic [15:0] len;
    logic [3:0]  stall;
    logic        flip;
    logic        kill;
    logic [3:0]  nb;
  } run_t;

  localparam int NRUN = 10;
  localparam run_t RUNS [NRUN] = '{
    '{2'd0, 1'b0, 16'd4, 4'd0, 1'b0, 1'b0, 4'd12},
    '{2'd1, 1'b0, 16'd4, 4'd0, 1'b0, 1'b0, 4'd12},
    '{2'd2, 1'b0, 16'd4, 4'd0, 1'b0, 1'b0, 4'd12},
    '{2'd2, 1'b1, 16'd4, 4'd0, 1'b0, 1'b0, 4'd12},
    '{2'd2, 1'b0, 16'd5, 4'd2, 1'b0, 1'b0, 4'd12},
    '{2'd2, 1'b0, 16'd4, 4'd0, 1'b0, 1'b1, 4'd12},
    '{2'd1, 1'b0, 16'd4, 4'd0, 1'b1, 1'b0, 4'd12},
    '{2'd2, 1'b1, 16'd3, 4'd0, 1'b0, 1'b0, 4'd1},
    '{2'd3, 1'b0, 16'd4, 4'd0, 1'b0, 1'b0, 4'd12},
    '{2'd0, 1'b1, 16'd4, 4'd3, 1'b1, 1'b0, 4'd12}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic        cfg_tie_first = 1'b0;
  logic [15:0] cfg_line_len = 16'd4;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic [15:0] in_p0 = '0, in_p1 = '0, in_p2 = '0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_slot [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  roi_stat_engine i_roi_stat_engine (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_tie_first(cfg_tie_first),
    .cfg_line_len(cfg_line_len), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_eof(in_eof), .in_p0(in_p0), .in_p1(in_p1), .in_p2(in_p2),
    .rd_idx(rd_idx), .rd_data(rd_data), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // expected values, computed directly from the requirement text
  task automatic compute_exp(input run_t r);
    longint s [6];
    longint sq, sp;
    int unsigned n, mnv, mxv, mnp, mxp;
    bit have;
    for (int k = 0; k < 6; k++) s[k] = 0;
    sq = 0; sp = 0; n = 0; have = 0;
    mnv = 0; mxv = 0; mnp = 0; mxp = 0;
    for (int i = 0; i < int'(r.nb); i++) begin
      logic [15:0] a, b, c;
      longint ga, gb, gc;
      int unsigned p;
      a = VEC[i][47:32];
      b = r.kill ? 16'h0 : VEC[i][31:16];
      c = VEC[i][15:0];
      ga = longint'($signed(a)); gb = longint'($signed(b)); gc = longint'($signed(c));
      s[0] += ga * gb; s[1] += ga * gc; s[2] += gb * gc;
      s[3] += gb * gb; s[4] += gc * gc; s[5] += (ga < 0) ? -ga : ga;
      p = {16'h0, (i / int'(r.len)) % 65536, 16'h0} >> 16;
      p = (((i / int'(r.len)) & 16'hFFFF) << 16) | ((i % int'(r.len)) & 16'hFFFF);
      if (b != 0) begin
        n++;
        sq += longint'(a) * longint'(a);
        sp += longint'(a);
        if (!have) begin
          mnv = a; mxv = a; mnp = p; mxp = p; have = 1;
        end else begin
          if (r.tie ? (a < mnv) : (a <= mnv)) begin mnv = a; mnp = p; end
          if (r.tie ? (a > mxv) : (a >= mxv)) begin mxv = a; mxp = p; end
        end
      end
    end
    for (int k = 0; k < 8; k++) exp_slot[k] = '0;
    case (r.mode)
      2'd0: for (int k = 0; k < 6; k++) exp_slot[k] = s[k][31:0];
      2'd1: begin
        exp_slot[0] = sq[31:0]; exp_slot[1] = sq[63:32];
        exp_slot[2] = sp[31:0]; exp_slot[3] = sp[63:32];
        exp_slot[4] = n;
      end
      2'd2: begin
        exp_slot[0] = n; exp_slot[1] = mnp; exp_slot[2] = mxp;
        exp_slot[3] = mnv; exp_slot[4] = mxv;
      end
      default: ;
    endcase
  endtask

  function automatic string tag_for(input run_t r, input int slot);
    if (slot >= 6)        return "R11";
    if (r.kill)           return "R7";
    if (r.flip)           return "R10";
    if (r.stall != 0)     return "R12";
    if (r.nb == 4'd1)     return "R9";
    case (r.mode)
      2'd0: return "R2";
      2'd1: return (slot == 4) ? "R4" : "R3";
      2'd2: return (slot == 0) ? "R5" : "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic run_frame(input run_t r);
    cfg_mode = r.mode; cfg_tie_first = r.tie; cfg_line_len = r.len;
    for (int i = 0; i < int'(r.nb); i++) begin
      if (i > 0) begin
        for (int st = 0; st < int'(r.stall); st++) begin
          // idle cycle carrying tempting garbage (R12)
          in_valid = 1'b0; in_sof = 1'b1; in_eof = 1'b1;
          in_p0 = 16'h0000; in_p1 = 16'hFFFF; in_p2 = 16'h7FFF;
          @(posedge clk); #1;
        end
      end
      in_valid = 1'b1;
      in_sof = (i == 0);
      in_eof = (i == int'(r.nb) - 1);
      in_p0 = VEC[i][47:32];
      in_p1 = r.kill ? 16'h0 : VEC[i][31:16];
      in_p2 = VEC[i][15:0];
      @(posedge clk); #1;
      if (r.flip && i == 0) begin
        // R10: late configuration change
        cfg_mode = (r.mode == 2'd0) ? 2'd1 : 2'd0;
        cfg_tie_first = ~r.tie;
        cfg_line_len = r.len + 16'd1;
      end
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    chk("R8", {31'b0, in_ready}, 32'd0);
    chk("R8", {31'b0, done}, 32'd0);
    @(posedge clk); #1;
    chk("R8", {31'b0, done}, 32'd1);
    chk("R8", {31'b0, in_ready}, 32'd1);
    @(posedge clk); #1;
    chk("R8", {31'b0, done}, 32'd0);
    compute_exp(r);
    for (int k = 0; k < 8; k++) begin
      rd_idx = 3'(k);
      #1;
      chk(tag_for(r, k), rd_data, exp_slot[k]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: reset state
    chk("R1", {31'b0, in_ready}, 32'd1);
    chk("R1", {31'b0, done}, 32'd0);
    for (int k = 0; k < 8; k++) begin
      rd_idx = 3'(k);
      #1;
      chk("R1", rd_data, 32'd0);
    end
    @(posedge clk); #1;
    for (int r = 0; r < NRUN; r++) begin
      run_frame(RUNS[r]);
      repeat (2) @(posedge clk);
      #1;
    end
    // R12: long idle stretch after results leaves slots unchanged
    in_valid = 1'b0; in_sof = 1'b1; in_eof = 1'b1; in_p1 = 16'hFFFF;
    repeat (5) @(posedge clk);
    #1;
    chk("R12", {31'b0, done}, 32'd0);
    for (int k = 0; k < 8; k++) begin
      rd_idx = 3'(k);
      #1;
      chk("R12", rd_data, exp_slot[k]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule